// File: doc/BRIEF.md
# Byte-Code UART Message Sequencer

This block runs a short program of byte codes held in a constant byte array fixed when the design is elaborated. The program decides what goes to a transmit UART's byte interface and when it goes there. It can pause for a timed interval, print a string, stall until a chosen character arrives from a receive UART, jump to an absolute address, or stop. The serial transmitter, the receiver and the baud generator sit outside the block. The block connects to their byte-wide sides: a data byte with a write strobe and a buffer-full flag on the transmit side, and a data byte with a valid strobe on the receive side.

The engine runs on every clock. Its course can only be steered through its inputs: a reset sends it back to address 0, and received characters release a pending wait. A typical program waits a while after power-up and prints a banner. It then waits for a keystroke, prints a second line, waits for another key and jumps back to the banner.

Top module: `msg_script_engine`

States: FETCH reads an opcode. OPERAND reads the byte that follows DELAY, WAIT and GOTO. DELAY counts time units. SEND streams message bytes. WAIT_CHAR compares received bytes. HALT is terminal. Transitions: FETCH to SEND on a message opcode. FETCH to OPERAND on delay, wait or jump. FETCH to HALT on the stop opcode or any unknown code. OPERAND to DELAY on a nonzero count, and to FETCH on a zero count or a jump. OPERAND to WAIT_CHAR on a wait. DELAY to FETCH when the last unit ends. SEND to FETCH on the end marker. WAIT_CHAR to FETCH on a matching byte. HALT leaves only by reset.

## Requirements
- R1: While reset is high the write strobe is low. After reset is released, execution restarts at address 0 in FETCH, and the cycle after release is counted as cycle 0.
- R2: Opcode 0x80 followed by count N pauses for N units of UNIT_CYCLES clocks. For a program that starts with 0x80 N and then a message, the first write strobe falls in cycle N*UNIT_CYCLES+4 after reset. A count of 0 adds no wait, so the gap between the last byte of one message and the first byte of the next message is N*UNIT_CYCLES+5 cycles.
- R3: Opcode 0x81 is followed by text bytes ended by the marker 0x00. The text bytes are written in order, one per cycle when the buffer is not full, and the marker is never written.
- R4: No byte is written in a cycle that follows a cycle where the buffer-full input was high. Each byte gets a one-cycle strobe in the cycle after the first cycle where buffer-full is sampled low.
- R5: Opcode 0x82 followed by byte C stalls until the receive strobe arrives with data equal to C, and discards all other received bytes. The first byte of a message that follows is written 3 cycles after the cycle of the match.
- R6: Received bytes that arrive while the engine is not waiting for a character have no effect.
- R7: Opcode 0x83 followed by address A loads the program counter with A, or with 0 if A lies beyond the array. Jumping from a match in cycle v to a message at A writes its first byte in cycle v+5.
- R8: Opcode 0x84, and any code that is not a defined opcode, stops execution. No byte is written again until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txq_full | input | 1 | Transmit buffer cannot take a byte |
| txq_wr | output | 1 | One-cycle write strobe to the transmit buffer |
| txq_byte | output | 8 | Byte presented with the write strobe |
| rxq_valid | input | 1 | One-cycle strobe that a received byte is present |
| rxq_byte | input | 8 | Received byte |

## Verification
The assertions assume that the receive strobe lasts a single cycle per character, and that the buffer-full flag may change in any cycle but is sampled only at the clock edge. They also assume that the program is well formed: every opcode that needs an operand has one, and every message ends with the marker. The bench drives its programs by hand to meet these terms. It raises each receive strobe for exactly one cycle between falling edges, and it moves buffer-full only on falling edges. This keeps every input stable around the active edge that the properties sample.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam logic [7:0] OP_PAUSE = 8'h80;
    localparam logic [7:0] OP_PRINT = 8'h81;
    localparam logic [7:0] OP_AWAIT = 8'h82;
    localparam logic [7:0] OP_JUMP  = 8'h83;
    localparam logic [7:0] OP_STOP  = 8'h84;
    localparam logic [7:0] END_MARK = 8'h00;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_OPND,
        ST_DELAY,
        ST_SEND,
        ST_WAIT,
        ST_HALT
    } st_e;
endpackage

// File: rtl/seq_rom.sv
module seq_rom #(
    parameter int unsigned          LEN   = 8,
    parameter int unsigned          AW    = 3,
    parameter logic [8*LEN-1:0]     IMAGE = '0
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    rd_byte
);
    logic [7:0] mem [LEN];

    for (genvar g = 0; g < LEN; g++) begin : g_cell
        assign mem[g] = IMAGE[8*g +: 8];
    end

    assign rd_byte = mem[addr];
endmodule

// File: rtl/seq_tick.sv
module seq_tick #(
    parameter int unsigned UNIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    if (UNIT_CYCLES <= 1) begin : g_flat
        logic unused_in;
        assign unused_in = ^{clk, rst, clr};
        assign tick = 1'b1;
    end else begin : g_cnt
        localparam int unsigned PW = $clog2(UNIT_CYCLES);
        localparam logic [PW-1:0] TOP = PW'(UNIT_CYCLES - 1);
        logic [PW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst || clr)
                cnt <= '0;
            else if (cnt == TOP)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end

        assign tick = (cnt == TOP);
    end
endmodule

// File: rtl/seq_dly.sv
module seq_dly (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] count,
    input  logic       tick,
    output logic [7:0] left,
    output logic       last
);
    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (load)
            left <= count;
        else if (tick && left != 8'd0)
            left <= left - 8'd1;
    end

    assign last = (left == 8'd1);
endmodule

// File: rtl/msg_script_engine.sv
module msg_script_engine #(
    parameter int unsigned             PROG_LEN    = 8,
    parameter int unsigned             UNIT_CYCLES = 16,
    parameter logic [8*PROG_LEN-1:0]   PROGRAM     = {8'h00, 8'h84, 8'h00, 8'h4B,
                                                      8'h4F, 8'h81, 8'h08, 8'h80}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       txq_full,
    output logic       txq_wr,
    output logic [7:0] txq_byte,
    input  logic       rxq_valid,
    input  logic [7:0] rxq_byte
);
    import seq_pkg::*;

    localparam int unsigned        ADDR_W  = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1;
    localparam logic [ADDR_W-1:0]  LAST_PC = ADDR_W'(PROG_LEN - 1);

    st_e               st, st_n;
    logic [ADDR_W-1:0] pc, pc_n;
    logic [7:0]        op, op_n;
    logic [7:0]        want, want_n;
    logic [7:0]        rom_b;
    logic [ADDR_W-1:0] jmp_tgt;
    logic              emit, dly_load, tick_clr, tick, dly_last;
    logic [7:0]        dly_left;

    function automatic logic [ADDR_W-1:0] pc_inc(input logic [ADDR_W-1:0] a);
        if (a == LAST_PC)
            return '0;
        return a + 1'b1;
    endfunction

    seq_rom #(.LEN(PROG_LEN), .AW(ADDR_W), .IMAGE(PROGRAM)) u_rom (
        .addr(pc), .rd_byte(rom_b)
    );

    seq_tick #(.UNIT_CYCLES(UNIT_CYCLES)) u_tick (
        .clk(clk), .rst(rst), .clr(tick_clr), .tick(tick)
    );

    seq_dly u_dly (
        .clk(clk), .rst(rst), .load(dly_load), .count(rom_b),
        .tick(tick), .left(dly_left), .last(dly_last)
    );

    assign jmp_tgt = ({24'd0, rom_b} < PROG_LEN) ? ADDR_W'(rom_b) : '0;

    // next-state and datapath decisions
    always_comb begin
        st_n     = st;
        pc_n     = pc;
        op_n     = op;
        want_n   = want;
        emit     = 1'b0;
        dly_load = 1'b0;
        tick_clr = 1'b0;
        unique case (st)
            ST_FETCH: begin
                pc_n = pc_inc(pc);
                op_n = rom_b;
                case (rom_b)
                    OP_PRINT:                    st_n = ST_SEND;
                    OP_PAUSE, OP_AWAIT, OP_JUMP: st_n = ST_OPND;
                    default:                     st_n = ST_HALT;
                endcase
            end
            ST_OPND: begin
                pc_n = pc_inc(pc);
                case (op)
                    OP_PAUSE: begin
                        dly_load = 1'b1;
                        tick_clr = 1'b1;
                        st_n     = (rom_b == 8'd0) ? ST_FETCH : ST_DELAY;
                    end
                    OP_AWAIT: begin
                        want_n = rom_b;
                        st_n   = ST_WAIT;
                    end
                    OP_JUMP: begin
                        pc_n = jmp_tgt;
                        st_n = ST_FETCH;
                    end
                    default: st_n = ST_HALT;
                endcase
            end
            ST_DELAY: begin
                if (tick && dly_last)
                    st_n = ST_FETCH;
            end
            ST_SEND: begin
                if (rom_b == END_MARK) begin
                    pc_n = pc_inc(pc);
                    st_n = ST_FETCH;
                end else if (!txq_full) begin
                    emit = 1'b1;
                    pc_n = pc_inc(pc);
                end
            end
            ST_WAIT: begin
                if (rxq_valid && rxq_byte == want)
                    st_n = ST_FETCH;
            end
            ST_HALT: st_n = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_FETCH;
            pc   <= '0;
            op   <= '0;
            want <= '0;
        end else begin
            st   <= st_n;
            pc   <= pc_n;
            op   <= op_n;
            want <= want_n;
        end
    end

    // registered transmit outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            txq_wr   <= 1'b0;
            txq_byte <= '0;
        end else begin
            txq_wr <= emit;
            if (emit)
                txq_byte <= rom_b;
        end
    end
endmodule

// File: rtl/msg_script_checks.sv
module msg_script_checks (
    input logic             clk,
    input logic             rst,
    input logic             txq_full,
    input logic             txq_wr,
    input logic [7:0]       txq_byte,
    input logic             rxq_valid,
    input logic [7:0]       rxq_byte,
    input seq_pkg::st_e     st,
    input logic [7:0]       want,
    input logic [7:0]       dly_left
);
    import seq_pkg::*;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !txq_wr);

    a_r2_delay_pending: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DELAY) |-> (dly_left != 8'd0));

    a_r3_marker_never_sent: assert property (@(posedge clk) disable iff (rst)
        txq_wr |-> (txq_byte != END_MARK));

    a_r4_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        txq_wr |-> !$past(txq_full));

    a_r5_wait_stalls: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && !(rxq_valid && rxq_byte == want)) |=> (st == ST_WAIT));

    a_r8_halt_silent: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HALT) |=> (st == ST_HALT && !txq_wr));
endmodule

bind msg_script_engine msg_script_checks u_chk (
    .clk(clk), .rst(rst), .txq_full(txq_full), .txq_wr(txq_wr),
    .txq_byte(txq_byte), .rxq_valid(rxq_valid), .rxq_byte(rxq_byte),
    .st(st), .want(want), .dly_left(dly_left)
);

// File: tb/sim_msg_script_engine.sv
`timescale 1ns/1ps
module sim_msg_script_engine;
    localparam int UNIT = 4;
    // main program: pause 3, "Hi", await '+', "ab", pause 0, "Z", await '-', jump 2
    localparam logic [8*21-1:0] PROG0 = {8'h02, 8'h83, 8'h2D, 8'h82, 8'h00, 8'h5A, 8'h81,
                                         8'h00, 8'h80, 8'h00, 8'h62, 8'h61, 8'h81, 8'h2B,
                                         8'h82, 8'h00, 8'h69, 8'h48, 8'h81, 8'h03, 8'h80};
    // halt program: "Q", stop, stray 'X'
    localparam logic [8*5-1:0] PROG1 = {8'h58, 8'h84, 8'h00, 8'h51, 8'h81};

    // expected write table: byte, reference event (0 reset, 1 '+', 2 '-'), offset, tag
    localparam int NV = 7;
    localparam logic [7:0] EXP_B   [NV] = '{8'h48, 8'h69, 8'h61, 8'h62, 8'h5A, 8'h48, 8'h69};
    localparam int         EXP_REF [NV] = '{0, 0, 1, 1, 1, 2, 2};
    localparam int         EXP_OFF [NV] = '{16, 17, 6, 7, 12, 5, 6};
    localparam string      EXP_TAG [NV] = '{"R2", "R3", "R4", "R3", "R2", "R7", "R3"};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txq_full = 1'b0;
    logic rxq_valid = 1'b0;
    logic [7:0] rxq_byte = 8'h00;
    logic txq_wr, u1_wr;
    logic [7:0] txq_byte, u1_byte;

    always #2.5 clk = ~clk;

    msg_script_engine #(.PROG_LEN(21), .UNIT_CYCLES(UNIT), .PROGRAM(PROG0)) u0 (
        .clk(clk), .rst(rst), .txq_full(txq_full), .txq_wr(txq_wr),
        .txq_byte(txq_byte), .rxq_valid(rxq_valid), .rxq_byte(rxq_byte)
    );

    msg_script_engine #(.PROG_LEN(5), .UNIT_CYCLES(UNIT), .PROGRAM(PROG1)) u1 (
        .clk(clk), .rst(rst), .txq_full(1'b0), .txq_wr(u1_wr),
        .txq_byte(u1_byte), .rxq_valid(1'b0), .rxq_byte(8'h00)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    logic [7:0] cap_d [64];
    int         cap_t [64];
    int         ncap = 0;
    int         n1 = 0;
    logic [7:0] last1 = 8'h00;

    always @(negedge clk) begin
        if (!rst && txq_wr && ncap < 64) begin
            cap_d[ncap] = txq_byte;
            cap_t[ncap] = cyc;
            ncap++;
        end
        if (!rst && u1_wr) begin
            n1++;
            last1 = u1_byte;
        end
    end

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int refc [3];
        int base;
        int n1a;
        refc[0] = 0;
        repeat (4) @(negedge clk);
        chk("R1 strobe in reset", int'(txq_wr), 0);
        rst = 1'b0;
        base = ncap;
        @(negedge clk);

        // R6: '+' during the start-up pause is dropped
        wait_cyc(5);
        rxq_byte = 8'h2B; rxq_valid = 1'b1;
        @(negedge clk) rxq_valid = 1'b0;

        // R5: wrong characters while awaiting '+'
        wait_cyc(25);
        rxq_byte = 8'h78; rxq_valid = 1'b1;
        @(negedge clk) rxq_valid = 1'b0;
        wait_cyc(30);
        rxq_byte = 8'h2D; rxq_valid = 1'b1;
        @(negedge clk) rxq_valid = 1'b0;
        wait_cyc(40);
        chk("R6 early key ignored", ncap - base, 2);

        // matching '+' with the buffer full for five cycles (R4)
        wait_cyc(45);
        refc[1] = cyc;
        txq_full = 1'b1;
        rxq_byte = 8'h2B; rxq_valid = 1'b1;
        @(negedge clk) rxq_valid = 1'b0;
        wait_cyc(refc[1] + 5);
        chk("R4 held while full", ncap - base, 2);
        txq_full = 1'b0;

        wait_cyc(80);
        chk("R5 stalled before '-'", ncap - base, 5);
        refc[2] = cyc;
        rxq_byte = 8'h2D; rxq_valid = 1'b1;
        @(negedge clk) rxq_valid = 1'b0;
        wait_cyc(refc[2] + 25);
        chk("R7 loop then await", ncap - base, 7);

        for (int i = 0; i < NV; i++) begin
            chk("R3 byte order", int'(cap_d[base + i]), int'(EXP_B[i]));
            chk(EXP_TAG[i], cap_t[base + i], refc[EXP_REF[i]] + EXP_OFF[i]);
        end

        // R8: halt program stays silent
        n1a = n1;
        chk("R8 single byte before halt", n1a, 1);
        chk("R8 halt byte value", int'(last1), 8'h51);

        // R1: reset mid-run restarts at address 0 with the pause again
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 strobe in second reset", int'(txq_wr), 0);
        rst = 1'b0;
        base = ncap;
        @(negedge clk);
        wait_cyc(30);
        chk("R1 restart count", ncap - base, 2);
        chk("R1 restart byte", int'(cap_d[base]), 8'h48);
        chk("R1 restart time", cap_t[base], 16);
        chk("R8 resumes after reset", n1, n1a + 1);

        finish_up();
    end
endmodule